// File: doc/BRIEF.md
# Polyphase Resampler Phase Stepper

This block produces the sampling positions for one axis of a polyphase resampler. On a start strobe it takes a source length, a destination length, the plane being processed (luma or chroma), the axis (horizontal or vertical), the chroma subsampling of the source, whether the destination is 4:2:2, and a chroma siting code. From these it derives the effective lengths for the selected plane. A sequential restoring divider then computes a fixed-point step with 13 fractional bits, rounded to nearest.

After the division the block walks a signed position accumulator from a start offset. For each output sample it offers an integer source index and a 4-bit filter phase over a valid/ready handshake. The chroma start offset is a negative fraction that depends on the siting code, so that chroma taps line up with the luma grid. Indices for positions left of zero are clamped to 0, which replicates the edge sample. When the last sample has been taken the block pulses done and returns to idle.

Top module: `phase_stepper`

## Requirements
- R1: The step output equals floor((S*8192 + floor(D/2)) / D), where S and D are the effective source and destination lengths. It is valid from the cycle in which busy falls.
- R2: Effective lengths. For the chroma plane (plane_chroma=1) the source length is halved (floor) on the horizontal axis (axis_vert=0) when src_sub is 1 (4:2:2) or 2 (4:2:0), and on the vertical axis only when src_sub is 2. The destination length is halved only for chroma on the horizontal axis with dst_422=1. Luma lengths and src_sub values 0 and 3 are used unchanged.
- R3: The start position is 0 for luma and for every src_sub other than 2. For chroma with src_sub=2, the vertical axis uses -2048 for siting codes 0 and 1 and -4096 for codes 4 and 5. The horizontal axis uses -2048 for codes 1, 3 and 5. Every other combination starts at 0.
- R4: Sample k (counting from 0) has position P = start + k*step. out_index is floor(P/8192) and out_phase is bits 12..9 of P in two's complement, i.e. floor(P/512) mod 16.
- R5: When P is negative, out_index is 0 and out_phase is still taken from P.
- R6: busy is high for exactly 25 cycles (LEN_W+13, one per quotient bit), starting in the cycle after an accepted start. out_valid stays low throughout.
- R7: Exactly D samples are offered, and out_last is high on the final one. done is high for a single cycle, the cycle after the final handshake.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_index and out_phase do not change.
- R9: A start strobe while busy or while samples are being offered is ignored. The step does not change and the current run completes with its own count.
- R10: When D is 0, no division runs and no sample is offered. done is high in the cycle after start.
- R11: After reset, busy, out_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when idle |
| plane_chroma | input | 1 | 1 selects the chroma plane, 0 luma |
| axis_vert | input | 1 | 1 selects the vertical axis, 0 horizontal |
| src_sub | input | 2 | Source subsampling: 0 4:4:4, 1 4:2:2, 2 4:2:0 |
| dst_422 | input | 1 | Destination is 4:2:2 |
| siting | input | 3 | Chroma siting code 0..5 |
| src_len | input | LEN_W | Source length in samples |
| dst_len | input | LEN_W | Destination length in samples |
| out_ready | input | 1 | Consumer accepts the offered sample |
| busy | output | 1 | Divider running |
| step | output | LEN_W+13 | Fixed-point step, 13 fractional bits |
| out_valid | output | 1 | Sample offered |
| out_index | output | LEN_W | Integer source index, clamped at 0 |
| out_phase | output | 4 | Filter phase |
| out_last | output | 1 | Offered sample is the final one |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest condition to reach from the ports is a negative accumulator, which only a chroma run on a 4:2:0 source with a nonzero siting offset produces. The stimulus table therefore holds 4:2:0 chroma rows for both axes and several siting codes, and checks the clamped index and the wrapped phase of the first samples. A second awkward case is a start strobe that arrives in the middle of a walk while the consumer is stalling. A directed run injects it at the third sample with out_ready low, then confirms that the step and the sample count belong to the original run.

// File: rtl/phase_stepper_pkg.sv
package phase_stepper_pkg;

  localparam int FRAC_W  = 13;
  localparam int PHASE_W = 4;
  localparam int START_W = 16;

  typedef enum logic [1:0] {
    SUB_444 = 2'd0,
    SUB_422 = 2'd1,
    SUB_420 = 2'd2
  } sub_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_WALK = 2'd2,
    ST_FIN  = 2'd3
  } step_state_e;

  // R2: source length is halved for subsampled chroma
  function automatic logic halve_src(logic chroma, logic vert, logic [1:0] sub);
    if (!chroma) return 1'b0;
    if (vert) return sub == SUB_420;
    return (sub == SUB_420) || (sub == SUB_422);
  endfunction

  // R2: destination length is halved for horizontal chroma into 4:2:2
  function automatic logic halve_dst(logic chroma, logic vert, logic d422);
    return chroma && !vert && d422;
  endfunction

  // R3: start offset from siting code
  function automatic logic signed [START_W-1:0] start_offset(
    logic chroma, logic vert, logic [1:0] sub, logic [2:0] site);
    logic signed [START_W-1:0] quarter, half;
    quarter = START_W'(-(1 << (FRAC_W - 2)));
    half    = START_W'(-(1 << (FRAC_W - 1)));
    if (!chroma || sub != SUB_420) return '0;
    if (vert) begin
      case (site)
        3'd0, 3'd1: return quarter;
        3'd4, 3'd5: return half;
        default:    return '0;
      endcase
    end
    case (site)
      3'd1, 3'd3, 3'd5: return quarter;
      default:          return '0;
    endcase
  endfunction

endpackage

// File: rtl/stepper_divider.sv
module stepper_divider #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             last,
  output logic [NUM_W-1:0] quotient
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W;

  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] num_sh_q, num_keep_q, quo_q;
  logic [DEN_W-1:0] den_q, rem_q;

  logic [DEN_W:0]   trial;
  logic             fits;
  logic [DEN_W-1:0] diff, rem_next;

  always_comb begin
    trial    = {rem_q, num_sh_q[NUM_W-1]};
    fits     = trial >= {1'b0, den_q};
    diff     = trial[DEN_W-1:0] - den_q;
    rem_next = fits ? diff : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      num_sh_q   <= '0;
      num_keep_q <= '0;
      quo_q      <= '0;
      den_q      <= '0;
      rem_q      <= '0;
    end else if (go) begin
      cnt_q      <= CNT_W'(NUM_W);
      num_sh_q   <= numer;
      num_keep_q <= numer;
      quo_q      <= '0;
      den_q      <= denom;
      rem_q      <= '0;
    end else if (cnt_q != '0) begin
      cnt_q    <= cnt_q - 1'b1;
      num_sh_q <= num_sh_q << 1;
      rem_q    <= rem_next;
      quo_q    <= {quo_q[NUM_W-2:0], fits};
    end
  end

  assign busy     = cnt_q != '0;
  assign last     = cnt_q == CNT_W'(1);
  assign quotient = quo_q;

  // R1: finished quotient and remainder reconstruct the numerator
  assert_quotient_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (PW'(quo_q) * PW'(den_q) + PW'(rem_q) == PW'(num_keep_q)) && (rem_q < den_q));

  // R6: counter never exceeds one step per quotient bit
  assert_div_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) - 1'b1) || $past(go));

endmodule

// File: rtl/stepper_walker.sv
module stepper_walker #(
  parameter int LEN_W   = 12,
  parameter int FRAC_W  = 13,
  parameter int PHASE_W = 4,
  parameter int NUM_W   = LEN_W + FRAC_W,
  parameter int ACC_W   = NUM_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] start_pos,
  input  logic                    advance,
  input  logic [NUM_W-1:0]        step,
  output logic [LEN_W-1:0]        index,
  output logic [PHASE_W-1:0]      phase
);
  logic signed [ACC_W-1:0] acc_q;

  function automatic logic [LEN_W-1:0] pos_to_index(logic signed [ACC_W-1:0] p);
    if (p[ACC_W-1]) return '0;          // R5: clamp left of the edge
    return p[ACC_W-2:FRAC_W];
  endfunction

  function automatic logic [PHASE_W-1:0] pos_to_phase(logic signed [ACC_W-1:0] p);
    return p[FRAC_W-1 -: PHASE_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (load)    acc_q <= start_pos;
    else if (advance) acc_q <= acc_q + $signed({1'b0, step});
  end

  assign index = pos_to_index(acc_q);
  assign phase = pos_to_phase(acc_q);

  // R4: source index never moves backwards during a walk
  assert_index_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> index >= $past(index));

endmodule

// File: rtl/phase_stepper.sv
module phase_stepper
  import phase_stepper_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      plane_chroma,
  input  logic                      axis_vert,
  input  logic [1:0]                src_sub,
  input  logic                      dst_422,
  input  logic [2:0]                siting,
  input  logic [LEN_W-1:0]          src_len,
  input  logic [LEN_W-1:0]          dst_len,
  input  logic                      out_ready,
  output logic                      busy,
  output logic [LEN_W+FRAC_W-1:0]   step,
  output logic                      out_valid,
  output logic [LEN_W-1:0]          out_index,
  output logic [PHASE_W-1:0]        out_phase,
  output logic                      out_last,
  output logic                      done
);
  localparam int NUM_W = LEN_W + FRAC_W;
  localparam int ACC_W = NUM_W + 1;

  step_state_e state_q;
  logic [LEN_W-1:0] dst_q, cnt_q;

  logic [LEN_W-1:0]        src_eff, dst_eff;
  logic [NUM_W-1:0]        numer;
  logic signed [ACC_W-1:0] start_acc;
  logic                    accept, go, div_busy, div_last, advance, final_sample;
  logic signed [START_W-1:0] offs;

  always_comb begin
    src_eff   = halve_src(plane_chroma, axis_vert, src_sub) ? (src_len >> 1) : src_len;
    dst_eff   = halve_dst(plane_chroma, axis_vert, dst_422) ? (dst_len >> 1) : dst_len;
    numer     = (NUM_W'(src_eff) << FRAC_W) + NUM_W'(dst_eff >> 1);
    offs      = start_offset(plane_chroma, axis_vert, src_sub, siting);
    start_acc = ACC_W'(offs);
  end

  assign accept       = start && (state_q == ST_IDLE);
  assign go           = accept && (dst_eff != '0);
  assign out_valid    = state_q == ST_WALK;
  assign advance      = out_valid && out_ready;
  assign final_sample = cnt_q == dst_q - LEN_W'(1);

  stepper_divider #(.NUM_W(NUM_W), .DEN_W(LEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .numer(numer), .denom(dst_eff),
    .busy(div_busy), .last(div_last), .quotient(step)
  );

  stepper_walker #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W),
                   .NUM_W(NUM_W), .ACC_W(ACC_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(go), .start_pos(start_acc),
    .advance(advance), .step(step), .index(out_index), .phase(out_phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          dst_q   <= dst_eff;
          cnt_q   <= '0;
          state_q <= (dst_eff == '0) ? ST_FIN : ST_DIV;
        end
        ST_DIV:  if (div_last) state_q <= ST_WALK;
        ST_WALK: if (advance) begin
          if (final_sample) state_q <= ST_FIN;
          else              cnt_q   <= cnt_q + LEN_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = state_q == ST_DIV;
  assign out_last = out_valid && final_sample;
  assign done     = state_q == ST_FIN;

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: offered sample holds under backpressure
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_index) && $stable(out_phase));

  // R9: a start during a walk does not relaunch the divider
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start) |=> !busy && $stable(step));

  // R10: zero destination length ends at once
  assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dst_eff == '0) |=> done && !div_busy);

  // R6: the divider and the sample handshake never overlap
  assert_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !out_valid);

endmodule

// File: tb/phase_stepper_test.sv
module phase_stepper_test;
  localparam int LEN_W = 12;
  localparam int NV = 11;
  localparam int NF = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, plane_chroma, axis_vert, dst_422, out_ready;
  logic [1:0] src_sub;
  logic [2:0] siting;
  logic [LEN_W-1:0] src_len, dst_len;
  logic busy, out_valid, out_last, done;
  logic [LEN_W+12:0] step;
  logic [LEN_W-1:0] out_index;
  logic [3:0] out_phase;

  phase_stepper #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .plane_chroma(plane_chroma),
    .axis_vert(axis_vert), .src_sub(src_sub), .dst_422(dst_422), .siting(siting),
    .src_len(src_len), .dst_len(dst_len), .out_ready(out_ready), .busy(busy),
    .step(step), .out_valid(out_valid), .out_index(out_index), .out_phase(out_phase),
    .out_last(out_last), .done(done)
  );

  int total = 0;
  int failed = 0;
  int cycles = 0;

  // chroma, vert, sub, d422, siting, src, dst, step, start, count
  localparam int VEC [NV][NF] = '{
    '{0, 0, 0, 0, 0, 100, 100,  8192,     0, 100},
    '{0, 1, 0, 0, 0, 100,  50, 16384,     0,  50},
    '{0, 0, 0, 0, 0,   3,   8,  3072,     0,   8},
    '{1, 1, 2, 0, 0,  64,  64,  4096, -2048,  64},
    '{1, 0, 2, 0, 1,  64,  48,  5461, -2048,  48},
    '{1, 1, 2, 0, 4,  10,   7,  5851, -4096,   7},
    '{1, 0, 1, 1, 0,  20,  30,  5461,     0,  15},
    '{1, 1, 1, 0, 0,  20,  10, 16384,     0,  10},
    '{1, 0, 2, 0, 2,   9,   3, 10923,     0,   3},
    '{0, 0, 0, 0, 0,   1,   3,  2731,     0,   3},
    '{1, 0, 0, 0, 1,  12,   6, 16384,     0,   6}
  };

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failed++;
      total++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, 150000);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic run(int v, bit inject);
    int n, k, cyc, h_idx, h_ph, pos, e_idx, e_ph;
    bit held, rdy, seen_done, injected, pending;
    @(negedge clk);
    plane_chroma = VEC[v][0][0];
    axis_vert    = VEC[v][1][0];
    src_sub      = VEC[v][2][1:0];
    dst_422      = VEC[v][3][0];
    siting       = VEC[v][4][2:0];
    src_len      = LEN_W'(VEC[v][5]);
    dst_len      = LEN_W'(VEC[v][6]);
    out_ready    = 1'b0;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      if (out_valid) check(1'b0, "R6", "valid while busy", 1, 0);
      n++;
      @(negedge clk);
    end
    check(n == 25, "R6", "busy cycles", n, 25);
    check(int'(step) == VEC[v][7], VEC[v][0] != 0 ? "R2" : "R1", "step", int'(step), VEC[v][7]);
    k = 0; cyc = 0; held = 0; seen_done = 0; injected = 0; pending = 0;
    h_idx = 0; h_ph = 0;
    while (!seen_done && cyc < 3000) begin
      if (done) begin
        seen_done = 1;
      end else begin
        if (held)
          check(out_valid && int'(out_index) == h_idx && int'(out_phase) == h_ph,
                "R8", "held index", int'(out_index), h_idx);
        rdy = (cyc % 3) != 1;
        if (inject && k == 2 && !injected) begin
          rdy = 1'b0; injected = 1; pending = 1;
          start = 1'b1; src_len = LEN_W'(77); dst_len = LEN_W'(50);
        end
        if (out_valid && rdy) begin
          pos   = VEC[v][8] + k * VEC[v][7];
          e_idx = pos < 0 ? 0 : (pos >>> 13);
          e_ph  = (pos >>> 9) & 15;
          check(int'(out_index) == e_idx, pos < 0 ? "R5" : "R4", "index", int'(out_index), e_idx);
          check(int'(out_phase) == e_ph, (k == 0 && VEC[v][0] != 0) ? "R3" : "R4",
                "phase", int'(out_phase), e_ph);
          check(out_last == (k == VEC[v][9] - 1), "R7", "last flag", int'(out_last),
                int'(k == VEC[v][9] - 1));
          k++;
        end
        held  = out_valid && !rdy;
        h_idx = int'(out_index);
        h_ph  = int'(out_phase);
        out_ready = rdy;
        @(negedge clk);
        cyc++;
        if (pending) begin
          start = 1'b0; pending = 0;
          check(!busy && int'(step) == VEC[v][7], "R9", "step after stray start",
                int'(step), VEC[v][7]);
        end
      end
    end
    check(seen_done && k == VEC[v][9], "R7", "sample count", k, VEC[v][9]);
    out_ready = 1'b0;
    @(negedge clk);
    check(!done, "R7", "done width", int'(done), 0);
  endtask

  task automatic zero_run(bit chroma, bit vert, bit d422, int dlen);
    @(negedge clk);
    plane_chroma = chroma; axis_vert = vert; dst_422 = d422;
    src_sub = 2'd1; siting = 3'd0;
    src_len = LEN_W'(40); dst_len = LEN_W'(dlen);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !out_valid && !busy, "R10", "done after zero length", int'(done), 1);
    @(negedge clk);
    check(!done && !out_valid && !busy, "R10", "idle after zero length", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; plane_chroma = 1'b0; axis_vert = 1'b0;
    dst_422 = 1'b0; out_ready = 1'b0; src_sub = 2'd0; siting = 3'd0;
    src_len = '0; dst_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid && !done, "R11", "reset state",
          int'({busy, out_valid, done}), 0);

    for (int v = 0; v < NV; v++) run(v, 1'b0);

    run(2, 1'b1);          // R9: stray start mid-walk
    zero_run(1'b0, 1'b0, 1'b0, 0);   // R10: luma zero length
    zero_run(1'b1, 1'b0, 1'b1, 1);   // R10: chroma 4:2:2 halves 1 to 0
    run(4, 1'b0);          // R3: reuse after zero-length runs

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule